// File: doc/BRIEF.md
# Four-Bit-Coded 32-Bit Arithmetic Logic Unit

This block is the arithmetic and logic stage of a single-cycle processor. It takes two 32-bit operands and a 4-bit operation code, and in the same cycle it returns a 32-bit result and a zero flag. It has no internal state. The operations are bitwise AND, OR and NOR, wrapping addition and subtraction, and a signed set-on-less-than. Loads and stores use it to form addresses. R-type instructions use it for their arithmetic. Branch-on-equal uses it by subtracting the two registers and testing the zero flag.

Internally, a decoder turns the operation code into a small bundle of strobes. One strobe selects the result source and one inverts the second operand. A datapath with a single shared adder produces every result from these strobes. The thin top connects the two and adds nothing else.

Top module: `alu32_core`

## Requirements
- R1: Code 4'b0000 gives the bitwise AND of the operands.
- R2: Code 4'b0001 gives the bitwise OR of the operands.
- R3: Code 4'b0010 gives opA + opB modulo 2^32, with no overflow indication.
- R4: Code 4'b0110 gives opA - opB modulo 2^32, with no overflow indication.
- R5: Code 4'b0111 gives 1 in bit 0 when opA < opB as two's-complement signed values, otherwise 0. Bits 31..1 are always zero. The comparison uses the true sign even when opA - opB overflows.
- R6: Code 4'b1100 gives the bitwise NOR of the operands.
- R7: `zero` is 1 exactly when all 32 result bits are 0. In particular, subtracting equal operands raises it.
- R8: Every other operation code gives a result of 0, and so `zero` is 1.
- R9: The outputs are a purely combinational function of the present inputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opA | input | 32 | First operand |
| opB | input | 32 | Second operand |
| opCode | input | 4 | Operation select |
| result | output | 32 | Operation result |
| zero | output | 1 | High when result is all zeros |

## Verification
The in-line assertions assume that `opA`, `opB` and `opCode` carry known values whenever they are evaluated. They also assume the checks run after the combinational logic has settled. The bench drives only defined values, away from the clock edge, and samples one time unit later. Random stimulus covers all sixteen codes, so the unused codes reach the zero-result check as often as the real ones. Directed cases add the signed-overflow comparisons, wrap-around and equal-operand subtraction.

// File: rtl/alu32_pkg.sv
package alu32_pkg;
  localparam int OP_W = 4;

  localparam logic [OP_W-1:0] OP_AND = 4'b0000;
  localparam logic [OP_W-1:0] OP_OR  = 4'b0001;
  localparam logic [OP_W-1:0] OP_ADD = 4'b0010;
  localparam logic [OP_W-1:0] OP_SUB = 4'b0110;
  localparam logic [OP_W-1:0] OP_SLT = 4'b0111;
  localparam logic [OP_W-1:0] OP_NOR = 4'b1100;

  // strobes from decoder to datapath
  typedef struct packed {
    logic selAnd;
    logic selOr;
    logic selNor;
    logic selSum;
    logic selSlt;
    logic invB;
  } aluCtl_t;
endpackage

// File: rtl/alu32_ctrl.sv
module alu32_ctrl
  import alu32_pkg::*;
(
  input  logic [OP_W-1:0] opCode,
  output aluCtl_t         ctl
);
  always_comb begin
    ctl = '0;
    unique case (opCode)
      OP_AND: ctl.selAnd = 1'b1;
      OP_OR:  ctl.selOr  = 1'b1;
      OP_NOR: ctl.selNor = 1'b1;
      OP_ADD: ctl.selSum = 1'b1;
      OP_SUB: begin ctl.selSum = 1'b1; ctl.invB = 1'b1; end
      OP_SLT: begin ctl.selSlt = 1'b1; ctl.invB = 1'b1; end
      default: ctl = '0; // R8: no source selected
    endcase
  end

  always_comb begin
    // R8: at most one source is ever selected
    a_r8_onehot_select: assert ($onehot0({ctl.selAnd, ctl.selOr, ctl.selNor, ctl.selSum, ctl.selSlt}));
    // R5: inversion only accompanies a subtracting use of the adder
    a_r5_inv_with_adder: assert (!ctl.invB || ctl.selSum || ctl.selSlt);
  end
endmodule

// File: rtl/alu32_datapath.sv
module alu32_datapath
  import alu32_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  aluCtl_t           ctl,
  output logic [DATA_W-1:0] result,
  output logic              zero
);
  localparam int MSB = DATA_W - 1;

  logic [DATA_W-1:0] bSel;
  logic [DATA_W:0]   sumExt;
  logic [DATA_W-1:0] sumVal;
  logic              ovf;
  logic              lessBit;
  logic [DATA_W-1:0] sltVal;

  // one shared adder serves add, subtract and compare
  assign bSel   = opB ^ {DATA_W{ctl.invB}};
  assign sumExt = {1'b0, opA} + {1'b0, bSel} + {{DATA_W{1'b0}}, ctl.invB};
  assign sumVal = sumExt[MSB:0];

  // true sign of a - b: flip the raw sign bit when the subtraction overflowed
  assign ovf     = (opA[MSB] == bSel[MSB]) && (sumVal[MSB] != opA[MSB]);
  assign lessBit = sumVal[MSB] ^ ovf;
  assign sltVal  = {{(DATA_W-1){1'b0}}, lessBit};

  always_comb begin
    result = ({DATA_W{ctl.selAnd}} & (opA & opB))
           | ({DATA_W{ctl.selOr}}  & (opA | opB))
           | ({DATA_W{ctl.selNor}} & ~(opA | opB))
           | ({DATA_W{ctl.selSum}} & sumVal)
           | ({DATA_W{ctl.selSlt}} & sltVal);
  end

  assign zero = ~|result;

  always_comb begin
    // R5: a comparison never sets any bit above bit 0
    if (ctl.selSlt) a_r5_slt_upper_clear: assert (result[MSB:1] == '0);
    // R8: with no source selected the result is all zeros
    if (!(ctl.selAnd | ctl.selOr | ctl.selNor | ctl.selSum | ctl.selSlt))
      a_r8_idle_zero: assert (result == '0);
  end
endmodule

// File: rtl/alu32_core.sv
module alu32_core
  import alu32_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic [OP_W-1:0]   opCode,
  output logic [DATA_W-1:0] result,
  output logic              zero
);
  aluCtl_t ctl;

  alu32_ctrl u_ctrl (
    .opCode (opCode),
    .ctl    (ctl)
  );

  alu32_datapath #(.DATA_W(DATA_W)) u_dp (
    .opA    (opA),
    .opB    (opB),
    .ctl    (ctl),
    .result (result),
    .zero   (zero)
  );

  always_comb begin
    // R3: addition wraps modulo 2^DATA_W
    if (opCode == OP_ADD) a_r3_add_wrap: assert (result == DATA_W'(opA + opB));
    // R4/R7: subtraction of equal operands raises zero
    if (opCode == OP_SUB && opA == opB) a_r7_eq_sub_zero: assert (zero);
    // R6: NOR is the complement of OR
    if (opCode == OP_NOR) a_r6_nor_complement: assert ((result | (opA | opB)) == '1);
  end
endmodule

// File: tb/tb_alu32_core.sv
module tb_alu32_core;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #4 clk = ~clk; // 125 MHz

  logic [31:0] opA, opB, result;
  logic [3:0]  opCode;
  logic        zero;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  alu32_core dut (
    .opA(opA), .opB(opB), .opCode(opCode), .result(result), .zero(zero)
  );

  function automatic logic [31:0] refAlu(logic [3:0] op, logic [31:0] a, logic [31:0] b);
    case (op)
      4'b0000: return a & b;
      4'b0001: return a | b;
      4'b0010: return a + b;
      4'b0110: return a - b;
      4'b0111: return ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
      4'b1100: return ~(a | b);
      default: return 32'd0;
    endcase
  endfunction

  function automatic string reqTag(logic [3:0] op);
    case (op)
      4'b0000: return "R1";
      4'b0001: return "R2";
      4'b0010: return "R3";
      4'b0110: return "R4";
      4'b0111: return "R5";
      4'b1100: return "R6";
      default: return "R8";
    endcase
  endfunction

  task automatic apply(logic [3:0] op, logic [31:0] a, logic [31:0] b, string tag);
    logic [31:0] expR;
    @(negedge clk);
    opCode = op; opA = a; opB = b;
    #1;
    expR = refAlu(op, a, b);
    total++;
    if (result !== expR) begin
      bad++;
      $display("FAIL %s result op=%b a=%h b=%h actual=%h expected=%h", tag, op, a, b, result, expR);
    end
    total++;
    if (zero !== (expR == 32'd0)) begin
      bad++;
      $display("FAIL R7 zero (%s) op=%b actual=%b expected=%b", tag, op, zero, (expR == 32'd0));
    end
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int unused;
    unused = $urandom(32'd1234);
    opA = '0; opB = '0; opCode = '0;
    repeat (3) @(posedge clk);
    rstN = 1'b1;
    // reset state: zero inputs, AND -> 0, zero high (R9, R1)
    apply(4'b0000, 32'h0, 32'h0, "R9");
    apply(4'b0000, 32'hF0F0_1234, 32'h0FF0_FF00, "R1");
    apply(4'b0001, 32'hF000_0001, 32'h0000_1000, "R2");
    apply(4'b0010, 32'hFFFF_FFFF, 32'h1, "R3");          // wraps to 0
    apply(4'b0010, 32'h7FFF_FFFF, 32'h1, "R3");          // no overflow flag
    apply(4'b0110, 32'h0, 32'h1, "R4");                  // wraps to all ones
    apply(4'b0110, 32'hDEAD_BEEF, 32'hDEAD_BEEF, "R7");  // equal -> zero
    apply(4'b0111, 32'h8000_0000, 32'h7FFF_FFFF, "R5");  // overflowing sub, less
    apply(4'b0111, 32'h7FFF_FFFF, 32'h8000_0000, "R5");  // overflowing sub, not less
    apply(4'b0111, 32'hFFFF_FFFF, 32'h0000_0001, "R5");  // -1 < 1
    apply(4'b0111, 32'h5, 32'h5, "R5");                  // equal -> 0
    apply(4'b1100, 32'h0, 32'h0, "R6");
    apply(4'b1100, 32'hAAAA_0000, 32'h5555_000F, "R6");
    for (int c = 0; c < 16; c++)
      if (reqTag(4'(c)) == "R8") apply(4'(c), 32'hFFFF_FFFF, 32'h1234_5678, "R8");
    for (int i = 0; i < 3000; i++) begin
      logic [3:0] op;
      logic [31:0] a, b;
      op = 4'($urandom_range(0, 15));
      a = $urandom();
      b = ($urandom_range(0, 7) == 0) ? a : $urandom();
      apply(op, a, b, reqTag(op));
    end
    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule